// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the register-facing half of a platform interrupt controller. It accepts 32-bit word accesses on a simple valid/ready bus and splits them across four sparse regions of a 24-bit address space. Those regions hold a priority value for each interrupt source, a set of enable words for each target context, a threshold for each context, and a claim/complete port for each context. The stored values go out as flat vectors to the selection logic, which sits outside this block. That selection logic returns the best pending source identifier for each context.

A read of a context's claim/complete slot returns that context's current best identifier. It also pulses a one-cycle claim strobe towards the per-context tracker. A write of an identifier to the same slot pulses a complete strobe, but only when the identifier is a real source that the context has enabled. Any access that lands on a reserved slot, on source 0, on a source or enable word past the configured count, or on a context past the configured count changes nothing and reads back zero. `NUM_SRC` must be a multiple of 32 and counts source 0, which does not exist. `NUM_CTX` sets the number of contexts.

Top module: `irqf_regs`

## Requirements
- R1: Address 4*s for 1 <= s < NUM_SRC holds the priority of source s. A write keeps wdata[3:0], and a read returns that value zero-extended. The value appears on prio_flat[4s+3:4s].
- R2: Writes to address 0x0 (source 0) and to priority addresses of sources s >= NUM_SRC leave prio_flat unchanged, and reads of them return 0.
- R3: Address 0x2000 + 0x80*c + 4*w holds enable word w of context c, where w < NUM_SRC/32. Bit b of that word enables source 32w+b and appears on enable_flat[c*NUM_SRC + 32w + b]. It reads back as written.
- R4: Bit 0 of enable word 0 of every context is stored as 0 whatever is written.
- R5: Address 0x200000 + 0x1000*c holds the threshold of context c. A write keeps wdata[3:0], and the value reads back zero-extended and appears on thresh_flat[4c+3:4c].
- R6: A read of 0x200004 + 0x1000*c returns best_id_flat slice c. In the cycle after the request, claim_strobe has only bit c set and evt_id equals that identifier, for one cycle.
- R7: A write of value v to 0x200004 + 0x1000*c pulses complete_strobe bit c for one cycle with evt_id = v, only when v < NUM_SRC and source v is enabled for context c. Otherwise no strobe occurs.
- R8: Accesses to a context index >= NUM_CTX, in either the enable or the control region, change nothing and read 0.
- R9: Address bits [1:0] are ignored.
- R10: Reserved slots read 0 and ignore writes. These are control offsets other than 0 and 4, enable words w >= NUM_SRC/32, and the area between the priority registers and 0x2000.
- R11: req_ready is always high. Each request cycle is followed by exactly one cycle with rsp_valid high, and rsp_rdata is 0 for writes. Idle cycles give rsp_valid low.
- R12: After synchronous reset all priorities, enables and thresholds are 0, rsp_valid is low and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Always accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address; bits [1:0] ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, 0 for writes and ignored reads |
| best_id_flat | input | NUM_CTX*ID_W | Best pending identifier per context, from the selector |
| prio_flat | output | NUM_SRC*PRIO_W | Stored source priorities |
| enable_flat | output | NUM_CTX*NUM_SRC | Stored enable bits, context-major |
| thresh_flat | output | NUM_CTX*PRIO_W | Stored context thresholds |
| claim_strobe | output | NUM_CTX | One-cycle claim event per context |
| complete_strobe | output | NUM_CTX | One-cycle complete event per context |
| evt_id | output | ID_W | Identifier carried by the last claim or complete |

## Verification
A request is presented for one clock edge. The response, the read data and any claim or complete strobe are all registered at that same edge, so they are due exactly one cycle after the request. Register contents on prio_flat, enable_flat and thresh_flat change at that same edge. The bench drives inputs on the falling edge and samples every result on the following falling edge, which is half a cycle after the edge that produced it. It then samples once more a cycle later to confirm that the strobes have dropped.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int ADDR_W = 24;

    // Region bases and stride exponents of the sparse map
    localparam logic [ADDR_W-1:0] EN_BASE   = 24'h002000;
    localparam logic [ADDR_W-1:0] CTRL_BASE = 24'h200000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_EN,
        RG_THR,
        RG_CLM
    } region_e;

    // unit: source id (priority) or context index (enable / control)
    // sel : enable word index, or control slot number
    typedef struct packed {
        region_e     region;
        logic [13:0] unit;
        logic [9:0]  sel;
    } dec_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Raw map of a word address into region and indices, without range limits
    function automatic dec_t map_addr(input logic [ADDR_W-1:0] a);
        dec_t              d;
        logic [ADDR_W-1:0] w;
        logic [ADDR_W-1:0] off;
        w   = {a[ADDR_W-1:2], 2'b00};
        d   = '{region: RG_NONE, unit: '0, sel: '0};
        off = '0;
        if (w < EN_BASE) begin
            d.region = RG_PRIO;
            d.unit   = {3'b000, w[12:2]};
        end else if (w < CTRL_BASE) begin
            off      = w - EN_BASE;
            d.region = RG_EN;
            d.unit   = off[20:7];
            d.sel    = {5'b00000, off[6:2]};
        end else begin
            off   = w - CTRL_BASE;
            d.unit = {2'b00, off[23:12]};
            d.sel  = off[11:2];
            if (off[11:2] == 10'd0)      d.region = RG_THR;
            else if (off[11:2] == 10'd1) d.region = RG_CLM;
            else                         d.region = RG_NONE;
        end
        return d;
    endfunction

endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int          EN_WORDS = NUM_SRC / 32;
    localparam logic [13:0] SRC_LIM  = 14'(NUM_SRC);
    localparam logic [13:0] CTX_LIM  = 14'(NUM_CTX);
    localparam logic [9:0]  WORD_LIM = 10'(EN_WORDS);

    dec_t raw;

    always_comb begin
        raw = map_addr(addr);
        dec = raw;
        unique case (raw.region)
            RG_PRIO: if (raw.unit == 14'd0 || raw.unit >= SRC_LIM)
                         dec.region = RG_NONE;
            RG_EN:   if (raw.unit >= CTX_LIM || raw.sel >= WORD_LIM)
                         dec.region = RG_NONE;
            RG_THR,
            RG_CLM:  if (raw.unit >= CTX_LIM)
                         dec.region = RG_NONE;
            default: dec.region = RG_NONE;
        endcase
    end

endmodule

// File: rtl/irqf_prio_store.sv
module irqf_prio_store
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [idx_w(NUM_SRC)-1:0] src,
    input  logic [PRIO_W-1:0]         wdata,
    output logic [PRIO_W-1:0]         rdata,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
    localparam int SRC_W = idx_w(NUM_SRC);

    logic [PRIO_W-1:0] prio_q [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[s] <= '0;
            else if (we && src == SRC_W'(s))
                prio_q[s] <= wdata;
        end
        assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

    assign rdata = prio_q[src];

    // R2: the decoder never steers a write to the absent source 0
    p_prio_no_src0_r2: assert property (@(posedge clk) disable iff (rst)
        we |-> src != '0);

endmodule

// File: rtl/irqf_ctx_store.sv
module irqf_ctx_store
    import irqf_pkg::*;
#(
    parameter int NUM_CTX  = 4,
    parameter int EN_WORDS = 2,
    parameter int PRIO_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                en_we,
    input  logic                                thr_we,
    input  logic [idx_w(NUM_CTX)-1:0]           ctx,
    input  logic [idx_w(EN_WORDS)-1:0]          word,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         en_rdata,
    output logic [PRIO_W-1:0]                   thr_rdata,
    output logic [NUM_CTX*EN_WORDS*32-1:0]      en_flat,
    output logic [NUM_CTX*PRIO_W-1:0]           thr_flat
);
    localparam int CTX_W  = idx_w(NUM_CTX);
    localparam int WORD_W = idx_w(EN_WORDS);
    localparam int ROW_W  = EN_WORDS * 32;

    logic [31:0]       en_q  [NUM_CTX][EN_WORDS];
    logic [PRIO_W-1:0] thr_q [NUM_CTX];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        for (genvar w = 0; w < EN_WORDS; w++) begin : g_word
            // source 0 does not exist: its enable bit cannot be set
            localparam logic [31:0] KEEP = (w == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
            always_ff @(posedge clk) begin
                if (rst)
                    en_q[c][w] <= '0;
                else if (en_we && ctx == CTX_W'(c) && word == WORD_W'(w))
                    en_q[c][w] <= wdata & KEEP;
            end
            assign en_flat[c*ROW_W + w*32 +: 32] = en_q[c][w];
        end

        always_ff @(posedge clk) begin
            if (rst)
                thr_q[c] <= '0;
            else if (thr_we && ctx == CTX_W'(c))
                thr_q[c] <= wdata[PRIO_W-1:0];
        end
        assign thr_flat[c*PRIO_W +: PRIO_W] = thr_q[c];

        // R5: a threshold changes only on a write addressed to its own context
        p_thr_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !(thr_we && ctx == CTX_W'(c)) |=> $stable(thr_q[c]));
    end

    assign en_rdata  = en_q[ctx][word];
    assign thr_rdata = thr_q[ctx];

endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4,
    parameter int PRIO_W  = 4,
    localparam int ID_W   = idx_w(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    input  logic [NUM_CTX*ID_W-1:0]   best_id_flat,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [NUM_CTX*NUM_SRC-1:0] enable_flat,
    output logic [NUM_CTX*PRIO_W-1:0] thresh_flat,
    output logic [NUM_CTX-1:0]        claim_strobe,
    output logic [NUM_CTX-1:0]        complete_strobe,
    output logic [ID_W-1:0]           evt_id
);
    localparam int EN_WORDS = NUM_SRC / 32;
    localparam int CTX_W    = idx_w(NUM_CTX);
    localparam int WORD_W   = idx_w(EN_WORDS);

    dec_t                dec;
    logic [CTX_W-1:0]    ctx;
    logic [ID_W-1:0]     src;
    logic [WORD_W-1:0]   word;
    logic [PRIO_W-1:0]   prio_rd;
    logic [31:0]         en_rd;
    logic [PRIO_W-1:0]   thr_rd;
    logic [ID_W-1:0]     best;
    logic [NUM_SRC-1:0]  en_row;
    logic                cmp_ok;
    logic [31:0]         rd_next;
    logic [NUM_CTX-1:0]  ctx_hot;
    logic                do_rd, do_wr;

    logic                rsp_valid_q;
    logic [31:0]         rsp_rdata_q;
    logic [NUM_CTX-1:0]  claim_q, complete_q;
    logic [ID_W-1:0]     evt_id_q;

    assign req_ready = 1'b1;
    assign do_rd     = req_valid && !req_write;
    assign do_wr     = req_valid && req_write;

    irqf_decode #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    assign ctx  = dec.unit[CTX_W-1:0];
    assign src  = dec.unit[ID_W-1:0];
    assign word = dec.sel[WORD_W-1:0];

    irqf_prio_store #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_prio (
        .clk       (clk),
        .rst       (rst),
        .we        (do_wr && dec.region == RG_PRIO),
        .src       (src),
        .wdata     (req_wdata[PRIO_W-1:0]),
        .rdata     (prio_rd),
        .prio_flat (prio_flat)
    );

    irqf_ctx_store #(.NUM_CTX(NUM_CTX), .EN_WORDS(EN_WORDS), .PRIO_W(PRIO_W)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .en_we     (do_wr && dec.region == RG_EN),
        .thr_we    (do_wr && dec.region == RG_THR),
        .ctx       (ctx),
        .word      (word),
        .wdata     (req_wdata),
        .en_rdata  (en_rd),
        .thr_rdata (thr_rd),
        .en_flat   (enable_flat),
        .thr_flat  (thresh_flat)
    );

    always_comb begin
        best    = best_id_flat[int'(ctx)*ID_W +: ID_W];
        en_row  = enable_flat[int'(ctx)*NUM_SRC +: NUM_SRC];
        cmp_ok  = (req_wdata < 32'(NUM_SRC)) && en_row[req_wdata[ID_W-1:0]];
        for (int c = 0; c < NUM_CTX; c++)
            ctx_hot[c] = (ctx == CTX_W'(c));
        unique case (dec.region)
            RG_PRIO: rd_next = 32'(prio_rd);
            RG_EN:   rd_next = en_rd;
            RG_THR:  rd_next = 32'(thr_rd);
            RG_CLM:  rd_next = 32'(best);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            claim_q     <= '0;
            complete_q  <= '0;
            evt_id_q    <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_rdata_q <= do_rd ? rd_next : '0;
            claim_q     <= (do_rd && dec.region == RG_CLM) ? ctx_hot : '0;
            complete_q  <= (do_wr && dec.region == RG_CLM && cmp_ok) ? ctx_hot : '0;
            if (do_rd && dec.region == RG_CLM)
                evt_id_q <= best;
            else if (do_wr && dec.region == RG_CLM && cmp_ok)
                evt_id_q <= req_wdata[ID_W-1:0];
        end
    end

    assign rsp_valid       = rsp_valid_q;
    assign rsp_rdata       = rsp_rdata_q;
    assign claim_strobe    = claim_q;
    assign complete_strobe = complete_q;
    assign evt_id          = evt_id_q;

    // R11: one response per request, none when idle
    p_rsp_next_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R6: at most one context claims, only after a read, carrying the returned id
    p_claim_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_strobe));
    p_claim_from_read_r6: assert property (@(posedge clk) disable iff (rst)
        |claim_strobe |-> $past(req_valid && !req_write) && rsp_rdata == 32'(evt_id));
    // R7: at most one context completes, only after a write
    p_complete_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(complete_strobe));
    p_complete_from_write_r7: assert property (@(posedge clk) disable iff (rst)
        |complete_strobe |-> $past(req_valid && req_write) && rsp_rdata == '0);

endmodule

// File: tb/irqf_regs_bench.sv
module irqf_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;
    localparam int NCTX = 4;
    localparam int PW   = 4;
    localparam int IDW  = 6;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  req_valid, req_write;
    logic                  req_ready;
    logic [23:0]           req_addr;
    logic [31:0]           req_wdata;
    logic                  rsp_valid;
    logic [31:0]           rsp_rdata;
    logic [NCTX*IDW-1:0]   best_id_flat;
    logic [NSRC*PW-1:0]    prio_flat;
    logic [NCTX*NSRC-1:0]  enable_flat;
    logic [NCTX*PW-1:0]    thresh_flat;
    logic [NCTX-1:0]       claim_strobe, complete_strobe;
    logic [IDW-1:0]        evt_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqf_regs #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(PW)) u_irqf_regs (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .rsp_valid       (rsp_valid),
        .rsp_rdata       (rsp_rdata),
        .best_id_flat    (best_id_flat),
        .prio_flat       (prio_flat),
        .enable_flat     (enable_flat),
        .thresh_flat     (thresh_flat),
        .claim_strobe    (claim_strobe),
        .complete_strobe (complete_strobe),
        .evt_id          (evt_id)
    );

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 24'h000004, 32'hFFFF_FFF5, 32'h0,         8'd1},  // R1
        '{1'b0, 24'h000004, 32'h0,         32'h5,         8'd1},  // R1
        '{1'b1, 24'h0000FC, 32'h0000_000A, 32'h0,         8'd1},  // R1 last source
        '{1'b0, 24'h0000FC, 32'h0,         32'hA,         8'd1},  // R1
        '{1'b1, 24'h000100, 32'h7,         32'h0,         8'd2},  // R2 source 64
        '{1'b0, 24'h000100, 32'h0,         32'h0,         8'd2},  // R2
        '{1'b1, 24'h000000, 32'h3,         32'h0,         8'd2},  // R2 source 0
        '{1'b0, 24'h000000, 32'h0,         32'h0,         8'd2},  // R2
        '{1'b1, 24'h002000, 32'hFFFF_FFFF, 32'h0,         8'd4},  // R4
        '{1'b0, 24'h002000, 32'h0,         32'hFFFF_FFFE, 8'd4},  // R4
        '{1'b1, 24'h002084, 32'h8000_0001, 32'h0,         8'd3},  // R3 ctx1 word1
        '{1'b0, 24'h002084, 32'h0,         32'h8000_0001, 8'd3},  // R3
        '{1'b0, 24'h002080, 32'h0,         32'h0,         8'd3},  // R3 ctx1 word0 untouched
        '{1'b1, 24'h002008, 32'h1,         32'h0,         8'd10}, // R10 word 2
        '{1'b0, 24'h002008, 32'h0,         32'h0,         8'd10}, // R10
        '{1'b1, 24'h002200, 32'h5,         32'h0,         8'd8},  // R8 ctx4 enable
        '{1'b0, 24'h002200, 32'h0,         32'h0,         8'd8},  // R8
        '{1'b1, 24'h201000, 32'h1234_567C, 32'h0,         8'd5},  // R5 ctx1
        '{1'b0, 24'h201000, 32'h0,         32'hC,         8'd5},  // R5
        '{1'b0, 24'h201003, 32'h0,         32'hC,         8'd9},  // R9
        '{1'b1, 24'h00000B, 32'h9,         32'h0,         8'd9},  // R9 source 2
        '{1'b0, 24'h000008, 32'h0,         32'h9,         8'd9},  // R9
        '{1'b0, 24'h201008, 32'h0,         32'h0,         8'd10}, // R10 slot 2
        '{1'b1, 24'h204000, 32'h3,         32'h0,         8'd8},  // R8 ctx4 thr
        '{1'b0, 24'h204000, 32'h0,         32'h0,         8'd8},  // R8
        '{1'b0, 24'h001000, 32'h0,         32'h0,         8'd10}, // R10 gap
        '{1'b0, 24'h003000, 32'h0,         32'h0,         8'd8},  // R8 ctx32
        '{1'b0, 24'h200000, 32'h0,         32'h0,         8'd5}   // R5 ctx0 thr still 0
    };

    logic [31:0]     s_rd;
    logic            s_v;
    logic [NCTX-1:0] s_cs, s_ps;
    logic [IDW-1:0]  s_id;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, sample results half a cycle after the capturing edge
    task automatic access(input logic wr, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        s_v  = rsp_valid;
        s_rd = rsp_rdata;
        s_cs = claim_strobe;
        s_ps = complete_strobe;
        s_id = evt_id;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    initial begin
        rst          = 1'b1;
        req_valid    = 1'b0;
        req_write    = 1'b0;
        req_addr     = '0;
        req_wdata    = '0;
        best_id_flat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 rsp_valid", 32'(rsp_valid), 32'h0);
        check("R12 strobes", 32'({claim_strobe, complete_strobe}), 32'h0);
        check("R12 prio zero", 32'(|prio_flat), 32'h0);
        check("R12 enable/thr zero", 32'(|{enable_flat, thresh_flat}), 32'h0);
        check("R11 ready", 32'(req_ready), 32'h1);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].data);
            check($sformatf("R11 vec%0d rsp_valid", i), 32'(s_v), 32'h1);
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), s_rd, VECS[i].exp);
        end

        // stored values at the outputs
        check("R1 prio_flat src1", 32'(prio_flat[7:4]), 32'h5);
        check("R2 prio_flat src0", 32'(prio_flat[3:0]), 32'h0);
        check("R9 prio_flat src2", 32'(prio_flat[11:8]), 32'h9);
        check("R4 enable ctx0 bit0", 32'(enable_flat[0]), 32'h0);
        check("R3 enable ctx1 src63/32", 32'({enable_flat[64+63], enable_flat[64+32]}), 32'h3);
        check("R8 enable ctx2/3 untouched", 32'(|enable_flat[4*64-1:2*64]), 32'h0);
        check("R5 thresh_flat", 32'(thresh_flat), 32'h0000_00C0);

        // R11 idle gives no response
        @(negedge clk);
        check("R11 idle", 32'(rsp_valid), 32'h0);

        // R6 claim read on context 2
        best_id_flat[2*IDW +: IDW] = 6'd37;
        best_id_flat[1*IDW +: IDW] = 6'd11;
        access(1'b0, 24'h202004, 32'h0);
        check("R6 claim rdata", s_rd, 32'd37);
        check("R6 claim strobe", 32'(s_cs), 32'h4);
        check("R6 claim id", 32'(s_id), 32'd37);
        check("R6 no complete", 32'(s_ps), 32'h0);
        @(negedge clk);
        check("R6 strobe one cycle", 32'(claim_strobe), 32'h0);
        access(1'b0, 24'h201006, 32'h0);
        check("R6 ctx1 claim rdata", s_rd, 32'd11);
        check("R6 ctx1 claim strobe", 32'(s_cs), 32'h2);

        // R7 complete writes on context 2
        access(1'b1, 24'h002104, 32'h0000_0020);
        check("R3 ctx2 word1 stored", 32'(enable_flat[2*64+37]), 32'h1);
        access(1'b1, 24'h202004, 32'd37);
        check("R7 complete strobe", 32'(s_ps), 32'h4);
        check("R7 complete id", 32'(s_id), 32'd37);
        check("R7 no claim", 32'(s_cs), 32'h0);
        check("R11 write rdata", s_rd, 32'h0);
        @(negedge clk);
        check("R7 strobe one cycle", 32'(complete_strobe), 32'h0);
        access(1'b1, 24'h202004, 32'd38);
        check("R7 disabled id", 32'(s_ps), 32'h0);
        access(1'b1, 24'h202004, 32'd64);
        check("R7 out of range id", 32'(s_ps), 32'h0);
        access(1'b1, 24'h202004, 32'd0);
        check("R7 id zero", 32'(s_ps), 32'h0);
        access(1'b1, 24'h201004, 32'd37);
        check("R7 other ctx not enabled", 32'(s_ps), 32'h0);
        access(1'b0, 24'h204004, 32'h0);
        check("R8 claim ctx4 rdata", s_rd, 32'h0);
        check("R8 claim ctx4 strobe", 32'(s_cs), 32'h0);

        // R12 reset clears stored state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 cleared", 32'(|{prio_flat, enable_flat, thresh_flat}), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule